// File: doc/BRIEF.md
# Burst Counter-Pattern Memory Tester

This block is an AXI4 master that exercises a memory region in two passes. In the fill pass it writes a running 128-bit counter into the region with fixed-length incrementing bursts. In the check pass it reads the region back with the same burst settings and compares every returned beat against a counter that starts again from its first value. Control is minimal: a start pulse launches a run, and done, pass and an error count report the outcome.

Each burst is 64 beats of 16 bytes, so one burst covers 1024 bytes. Bursts sit back to back from byte address zero. The region length is a parameter counted in bursts. Each write burst has only one outstanding transaction: the next address is issued after the response to the previous one arrives. The read pass starts once the last write response is in.

All five AXI channels follow valid/ready rules. On AW, W and AR the block raises valid and holds it with a stable payload until the slave accepts it. On B and R the block holds ready high for the whole time it waits for the slave. A beat moves on any clock edge where valid and ready are both high. A slave may stall any channel for any number of cycles.

Top module: `axi_pattern_tester`

## Requirements
- R1: After reset, AWVALID, WVALID and ARVALID are low, done and pass are low, and the error count is zero.
- R2: An accepted start begins the fill pass. Write burst k (from 0) uses byte address k×1024, AWLEN 63, AWSIZE 4 (16 bytes per beat) and AWBURST 2'b01 (INCR).
- R3: Once AWVALID, WVALID or ARVALID is raised, it stays high until the matching ready is seen. Its address, or its data and WLAST, stays unchanged during that time.
- R4: Write data on the n-th accepted W beat of a run (counting from 0 across all bursts) equals n. WSTRB is all ones. WLAST is high exactly on the 64th beat of each burst.
- R5: A new AW request is never presented while a previous write burst still lacks its B response.
- R6: Every B response whose BRESP is not 2'b00 (OKAY) adds one to the error count.
- R7: ARVALID rises only after the B response of the last write burst. Read burst k uses address k×1024, ARLEN 63, ARSIZE 4 and ARBURST INCR. The expected counter restarts at 0.
- R8: On each accepted R beat, the error count gains one for each fault found: data not equal to the expected counter, RRESP not 2'b00, or RLAST differing from "this is the 64th beat of the burst".
- R9: Done rises after the last read beat and stays high until the next accepted start. Pass equals done with a zero error count.
- R10: A start pulse while a run is in progress has no effect.
- R11: An accepted start clears the error count. The count never decreases during a run and saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a run (accepted when idle or done) |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished with no errors |
| err_count | output | ERR_W | Saturating error count |
| awaddr | output | ADDR_W | Write burst address |
| awlen | output | 8 | Write burst length minus one |
| awsize | output | 3 | Write beat size code |
| awburst | output | 2 | Write burst type |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| wdata | output | DATA_W | Write data |
| wstrb | output | DATA_W/8 | Write byte strobes |
| wlast | output | 1 | Final write beat of burst |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| bresp | input | 2 | Write response code |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |
| araddr | output | ADDR_W | Read burst address |
| arlen | output | 8 | Read burst length minus one |
| arsize | output | 3 | Read beat size code |
| arburst | output | 2 | Read burst type |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| rdata | input | DATA_W | Read data |
| rresp | input | 2 | Read response code |
| rlast | input | 1 | Final read beat flag from slave |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready |

## Verification
The bench checks the burst address stride and the data stored by a slave model. A design that stepped the address by the wrong shift, or reset its counter at each burst, would leave holes or repeated values in the model memory. Random ready stalls on every channel catch a master that drops or changes a request before it is accepted. Injected faults check the error tally: a bad write response, a corrupted beat, a beat with a wrong data value and a bad response code together (two errors), a missing RLAST and an early RLAST. A flood of corrupt beats checks that the count saturates. Start pulses in the middle of a run and after done show whether a run can be restarted by accident and whether done holds.

// File: rtl/axi_pat_pkg.sv
`timescale 1ns/1ps
package axi_pat_pkg;
  localparam logic [1:0] RESP_OKAY  = 2'b00;
  localparam logic [1:0] BURST_INCR = 2'b01;

  typedef enum logic [1:0] {PH_IDLE, PH_WRITE, PH_READ, PH_DONE} phase_e;
  typedef enum logic [1:0] {WE_IDLE, WE_ADDR, WE_DATA, WE_RESP} wr_state_e;
  typedef enum logic [1:0] {RE_IDLE, RE_ADDR, RE_DATA} rd_state_e;
endpackage

// File: rtl/apt_write_eng.sv
`timescale 1ns/1ps
module apt_write_eng
  import axi_pat_pkg::*;
#(
  parameter int ADDR_W     = 30,
  parameter int DATA_W     = 128,
  parameter int BEATS      = 64,
  parameter int NUM_BURSTS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  output logic              finished,
  output logic              err_inc,
  output logic [ADDR_W-1:0] awaddr,
  output logic              awvalid,
  input  logic              awready,
  output logic [DATA_W-1:0] wdata,
  output logic              wlast,
  output logic              wvalid,
  input  logic              wready,
  input  logic [1:0]        bresp,
  input  logic              bvalid,
  output logic              bready
);
  localparam int BEAT_W      = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int BI_W        = (NUM_BURSTS > 1) ? $clog2(NUM_BURSTS) : 1;
  localparam int BURST_BYTES = BEATS * (DATA_W / 8);

  wr_state_e         st;
  logic [BEAT_W-1:0] beat;
  logic [BI_W-1:0]   burst;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] cnt;
  logic              last_beat, last_burst;

  assign last_beat  = (beat == BEAT_W'(BEATS - 1));
  assign last_burst = (burst == BI_W'(NUM_BURSTS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= WE_IDLE;
      beat  <= '0;
      burst <= '0;
      addr  <= '0;
      cnt   <= '0;
    end else begin
      case (st)
        WE_IDLE: if (go) begin
          st    <= WE_ADDR;
          addr  <= '0;
          burst <= '0;
          cnt   <= '0;
        end
        WE_ADDR: if (awready) begin
          st   <= WE_DATA;
          beat <= '0;
        end
        WE_DATA: if (wready) begin
          cnt  <= cnt + DATA_W'(1);
          beat <= beat + BEAT_W'(1);
          if (last_beat) st <= WE_RESP;
        end
        WE_RESP: if (bvalid) begin
          if (last_burst) begin
            st <= WE_IDLE;
          end else begin
            st    <= WE_ADDR;
            burst <= burst + BI_W'(1);
            addr  <= addr + ADDR_W'(BURST_BYTES);
          end
        end
        default: st <= WE_IDLE;
      endcase
    end
  end

  always_comb begin
    awvalid  = (st == WE_ADDR);
    awaddr   = addr;
    wvalid   = (st == WE_DATA);
    wdata    = cnt;
    wlast    = wvalid && last_beat;
    bready   = (st == WE_RESP);
    finished = bready && bvalid && last_burst;
    err_inc  = bready && bvalid && (bresp != RESP_OKAY);
  end
endmodule

// File: rtl/apt_read_eng.sv
`timescale 1ns/1ps
module apt_read_eng
  import axi_pat_pkg::*;
#(
  parameter int ADDR_W     = 30,
  parameter int DATA_W     = 128,
  parameter int BEATS      = 64,
  parameter int NUM_BURSTS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  output logic              finished,
  output logic [1:0]        err_inc,
  output logic [ADDR_W-1:0] araddr,
  output logic              arvalid,
  input  logic              arready,
  input  logic [DATA_W-1:0] rdata,
  input  logic [1:0]        rresp,
  input  logic              rlast,
  input  logic              rvalid,
  output logic              rready
);
  localparam int BEAT_W      = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int BI_W        = (NUM_BURSTS > 1) ? $clog2(NUM_BURSTS) : 1;
  localparam int BURST_BYTES = BEATS * (DATA_W / 8);

  rd_state_e         st;
  logic [BEAT_W-1:0] beat;
  logic [BI_W-1:0]   burst;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] expect_q;
  logic              hs, last_beat, last_burst;
  logic              f_data, f_resp, f_last;

  assign last_beat  = (beat == BEAT_W'(BEATS - 1));
  assign last_burst = (burst == BI_W'(NUM_BURSTS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= RE_IDLE;
      beat     <= '0;
      burst    <= '0;
      addr     <= '0;
      expect_q <= '0;
    end else begin
      case (st)
        RE_IDLE: if (go) begin
          st       <= RE_ADDR;
          addr     <= '0;
          burst    <= '0;
          expect_q <= '0;
        end
        RE_ADDR: if (arready) begin
          st   <= RE_DATA;
          beat <= '0;
        end
        RE_DATA: if (rvalid) begin
          expect_q <= expect_q + DATA_W'(1);
          beat     <= beat + BEAT_W'(1);
          if (last_beat) begin
            if (last_burst) begin
              st <= RE_IDLE;
            end else begin
              st    <= RE_ADDR;
              burst <= burst + BI_W'(1);
              addr  <= addr + ADDR_W'(BURST_BYTES);
            end
          end
        end
        default: st <= RE_IDLE;
      endcase
    end
  end

  always_comb begin
    arvalid  = (st == RE_ADDR);
    araddr   = addr;
    rready   = (st == RE_DATA);
    hs       = rready && rvalid;
    f_data   = hs && (rdata != expect_q);
    f_resp   = hs && (rresp != RESP_OKAY);
    f_last   = hs && (rlast != last_beat);
    err_inc  = {1'b0, f_data} + {1'b0, f_resp} + {1'b0, f_last};
    finished = hs && last_beat && last_burst;
  end
endmodule

// File: rtl/axi_pattern_tester.sv
`timescale 1ns/1ps
module axi_pattern_tester
  import axi_pat_pkg::*;
#(
  parameter int ADDR_W     = 30,
  parameter int DATA_W     = 128,
  parameter int BEATS      = 64,
  parameter int NUM_BURSTS = 4,
  parameter int ERR_W      = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  output logic                  done,
  output logic                  pass,
  output logic [ERR_W-1:0]      err_count,
  output logic [ADDR_W-1:0]     awaddr,
  output logic [7:0]            awlen,
  output logic [2:0]            awsize,
  output logic [1:0]            awburst,
  output logic                  awvalid,
  input  logic                  awready,
  output logic [DATA_W-1:0]     wdata,
  output logic [DATA_W/8-1:0]   wstrb,
  output logic                  wlast,
  output logic                  wvalid,
  input  logic                  wready,
  input  logic [1:0]            bresp,
  input  logic                  bvalid,
  output logic                  bready,
  output logic [ADDR_W-1:0]     araddr,
  output logic [7:0]            arlen,
  output logic [2:0]            arsize,
  output logic [1:0]            arburst,
  output logic                  arvalid,
  input  logic                  arready,
  input  logic [DATA_W-1:0]     rdata,
  input  logic [1:0]            rresp,
  input  logic                  rlast,
  input  logic                  rvalid,
  output logic                  rready
);
  localparam int SIZE_CODE = $clog2(DATA_W / 8);

  phase_e           phase;
  logic             launch, busy;
  logic             wr_fin, rd_fin, wr_err;
  logic [1:0]       rd_err;
  logic [ERR_W:0]   err_sum;

  assign busy   = (phase == PH_WRITE) || (phase == PH_READ);
  assign launch = start && !busy;

  apt_write_eng #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS(BEATS), .NUM_BURSTS(NUM_BURSTS)
  ) u_wr (
    .clk(clk), .rst_n(rst_n), .go(launch), .finished(wr_fin), .err_inc(wr_err),
    .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
    .wdata(wdata), .wlast(wlast), .wvalid(wvalid), .wready(wready),
    .bresp(bresp), .bvalid(bvalid), .bready(bready)
  );

  apt_read_eng #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS(BEATS), .NUM_BURSTS(NUM_BURSTS)
  ) u_rd (
    .clk(clk), .rst_n(rst_n), .go(wr_fin), .finished(rd_fin), .err_inc(rd_err),
    .araddr(araddr), .arvalid(arvalid), .arready(arready),
    .rdata(rdata), .rresp(rresp), .rlast(rlast), .rvalid(rvalid), .rready(rready)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
    end else begin
      case (phase)
        PH_IDLE, PH_DONE: if (launch) phase <= PH_WRITE;
        PH_WRITE:         if (wr_fin) phase <= PH_READ;
        PH_READ:          if (rd_fin) phase <= PH_DONE;
        default:          phase <= PH_IDLE;
      endcase
    end
  end

  assign err_sum = {1'b0, err_count} + (ERR_W + 1)'(wr_err) + (ERR_W + 1)'(rd_err);

  always_ff @(posedge clk) begin
    if (!rst_n || launch) begin
      err_count <= '0;
    end else if (err_sum[ERR_W]) begin
      err_count <= '1;
    end else begin
      err_count <= err_sum[ERR_W-1:0];
    end
  end

  always_comb begin
    done    = (phase == PH_DONE);
    pass    = done && (err_count == '0);
    awlen   = 8'(BEATS - 1);
    awsize  = 3'(SIZE_CODE);
    awburst = BURST_INCR;
    wstrb   = '1;
    arlen   = 8'(BEATS - 1);
    arsize  = 3'(SIZE_CODE);
    arburst = BURST_INCR;
  end
endmodule

// File: rtl/apt_checker.sv
`timescale 1ns/1ps
module apt_checker #(
  parameter int ADDR_W     = 30,
  parameter int DATA_W     = 128,
  parameter int BEATS      = 64,
  parameter int NUM_BURSTS = 4,
  parameter int ERR_W      = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [ERR_W-1:0]  err_count,
  input logic [ADDR_W-1:0] awaddr,
  input logic              awvalid,
  input logic              awready,
  input logic [DATA_W-1:0] wdata,
  input logic              wlast,
  input logic              wvalid,
  input logic              wready,
  input logic              bvalid,
  input logic              bready,
  input logic [ADDR_W-1:0] araddr,
  input logic              arvalid,
  input logic              arready
);
  localparam int BURST_BYTES = BEATS * (DATA_W / 8);

  int unsigned wbeat;
  int unsigned bcount;
  logic        wr_open;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wbeat   <= 0;
      bcount  <= 0;
      wr_open <= 1'b0;
    end else begin
      if (wvalid && wready) wbeat <= (wbeat == BEATS - 1) ? 0 : wbeat + 1;
      if (awvalid && awready) wr_open <= 1'b1;
      else if (bvalid && bready) wr_open <= 1'b0;
      if (start && !busy) bcount <= 0;
      else if (bvalid && bready) bcount <= bcount + 1;
    end
  end

  a_r3_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid && !awready |=> awvalid && $stable(awaddr));
  a_r3_w_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid && !wready |=> wvalid && $stable(wdata) && $stable(wlast));
  a_r3_ar_hold: assert property (@(posedge clk) disable iff (!rst_n)
    arvalid && !arready |=> arvalid && $stable(araddr));
  a_r2_aw_stride: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid |-> (awaddr % BURST_BYTES) == 0);
  a_r4_wlast_pos: assert property (@(posedge clk) disable iff (!rst_n)
    wvalid |-> (wlast == (wbeat == BEATS - 1)));
  a_r5_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid |-> !wr_open);
  a_r7_read_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    arvalid |-> (bcount == NUM_BURSTS) && !wr_open);
  a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);
  a_r11_err_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && !busy) |=> err_count >= $past(err_count));
endmodule

bind axi_pattern_tester apt_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS(BEATS), .NUM_BURSTS(NUM_BURSTS), .ERR_W(ERR_W)
) u_apt_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err_count(err_count), .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
  .wdata(wdata), .wlast(wlast), .wvalid(wvalid), .wready(wready),
  .bvalid(bvalid), .bready(bready), .araddr(araddr), .arvalid(arvalid),
  .arready(arready)
);

// File: tb/test_axi_pattern_tester.sv
`timescale 1ns/1ps
module test_axi_pattern_tester;
  localparam int AW    = 30;
  localparam int DW    = 128;
  localparam int NBEAT = 64;
  localparam int NB    = 4;
  localparam int EW    = 4;
  localparam int TOTAL = NB * NBEAT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic done, pass;
  logic [EW-1:0] err_count;
  logic [AW-1:0] awaddr, araddr;
  logic [7:0] awlen, arlen;
  logic [2:0] awsize, arsize;
  logic [1:0] awburst, arburst;
  logic awvalid, wvalid, wlast, bready, arvalid, rready;
  logic awready, wready, arready, bvalid, rvalid, rlast;
  logic [1:0] bresp, rresp;
  logic [DW-1:0] wdata, rdata;
  logic [DW/8-1:0] wstrb;

  always #2 clk = ~clk;

  axi_pattern_tester #(.ADDR_W(AW), .DATA_W(DW), .BEATS(NBEAT), .NUM_BURSTS(NB), .ERR_W(EW))
  i_axi_pattern_tester (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .pass(pass), .err_count(err_count),
    .awaddr(awaddr), .awlen(awlen), .awsize(awsize), .awburst(awburst), .awvalid(awvalid),
    .awready(awready), .wdata(wdata), .wstrb(wstrb), .wlast(wlast), .wvalid(wvalid),
    .wready(wready), .bresp(bresp), .bvalid(bvalid), .bready(bready), .araddr(araddr),
    .arlen(arlen), .arsize(arsize), .arburst(arburst), .arvalid(arvalid), .arready(arready),
    .rdata(rdata), .rresp(rresp), .rlast(rlast), .rvalid(rvalid), .rready(rready)
  );

  int checks = 0;
  int errors = 0;

  // slave model controls
  logic stall_en = 1'b0;
  logic clr = 1'b0;
  int   bad_b_burst = -1;
  logic flip_d [0:TOTAL-1];
  logic bad_r  [0:TOTAL-1];
  logic inv_l  [0:TOTAL-1];

  // slave model state and logs
  logic [DW-1:0] mem [0:TOTAL-1];
  logic [15:0] lfsr;
  logic aw_have, r_have;
  logic [AW-1:0] aw_base, r_base;
  int wbeat, rbeat, widx, ridx, nbeat;
  logic rhs, ract;
  int aw_n, ar_n, b_n;
  int attr_err, strb_err, wlast_err, proto_err, order_err, hold_err;
  logic [AW-1:0] aw_log [0:7];
  logic [AW-1:0] ar_log [0:7];

  always @(posedge clk) begin
    if (!rst_n) begin
      awready <= 0; wready <= 0; arready <= 0; bvalid <= 0; bresp <= 0;
      rvalid <= 0; rdata <= '0; rresp <= 0; rlast <= 0;
      aw_have <= 0; r_have <= 0; aw_base <= '0; r_base <= '0; wbeat <= 0; rbeat <= 0;
      lfsr <= 16'hACE1;
      aw_n <= 0; ar_n <= 0; b_n <= 0;
      attr_err <= 0; strb_err <= 0; wlast_err <= 0; proto_err <= 0; order_err <= 0;
    end else begin
      lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      awready <= stall_en ? lfsr[0] : 1'b1;
      wready  <= stall_en ? (lfsr[1] | lfsr[2]) : 1'b1;
      arready <= stall_en ? lfsr[3] : 1'b1;

      if (awvalid && awready) begin
        if (aw_have || bvalid) proto_err <= proto_err + 1;
        if (awlen != 8'd63 || awsize != 3'd4 || awburst != 2'b01) attr_err <= attr_err + 1;
        aw_have <= 1'b1;
        aw_base <= awaddr;
        wbeat   <= 0;
        if (aw_n < 8) aw_log[aw_n] <= awaddr;
        aw_n <= aw_n + 1;
      end
      if (wvalid && wready) begin
        if (!aw_have) begin
          proto_err <= proto_err + 1;
        end else begin
          widx = int'(aw_base >> 4) + wbeat;
          if (widx < TOTAL) mem[widx] <= wdata;
          if (wstrb != '1) strb_err <= strb_err + 1;
          if (wlast != (wbeat == NBEAT - 1)) wlast_err <= wlast_err + 1;
          wbeat <= wbeat + 1;
          if (wbeat == NBEAT - 1) begin
            aw_have <= 1'b0;
            bvalid  <= 1'b1;
            bresp   <= (int'(aw_base >> 10) == bad_b_burst) ? 2'b10 : 2'b00;
          end
        end
      end
      if (bvalid && bready) begin
        bvalid <= 1'b0;
        b_n    <= b_n + 1;
      end

      if (arvalid && arready) begin
        if (b_n != NB || aw_have || bvalid) order_err <= order_err + 1;
        if (arlen != 8'd63 || arsize != 3'd4 || arburst != 2'b01) attr_err <= attr_err + 1;
        if (ar_n < 8) ar_log[ar_n] <= araddr;
        ar_n   <= ar_n + 1;
        r_have <= 1'b1;
        r_base <= araddr;
        rbeat  <= 0;
      end
      rhs   = rvalid && rready;
      nbeat = rbeat + (rhs ? 1 : 0);
      ract  = r_have && !(rhs && rbeat == NBEAT - 1);
      if (rhs) begin
        rbeat <= nbeat;
        if (rbeat == NBEAT - 1) r_have <= 1'b0;
      end
      if (!rvalid || rhs) begin
        if (ract && (!stall_en || lfsr[4])) begin
          ridx   = int'(r_base >> 4) + nbeat;
          rvalid <= 1'b1;
          rdata  <= mem[ridx] ^ DW'(flip_d[ridx]);
          rresp  <= bad_r[ridx] ? 2'b10 : 2'b00;
          rlast  <= (nbeat == NBEAT - 1) ^ inv_l[ridx];
        end else begin
          rvalid <= 1'b0;
        end
      end

      if (clr) begin
        aw_n <= 0; ar_n <= 0; b_n <= 0;
        attr_err <= 0; strb_err <= 0; wlast_err <= 0; proto_err <= 0; order_err <= 0;
      end
    end
  end

  // hold monitor for requests under back-pressure
  logic p_awv, p_awr, p_wv, p_wr, p_arv, p_arr, p_wl;
  logic [AW-1:0] p_awa, p_ara;
  logic [DW-1:0] p_wd;
  always @(posedge clk) begin
    if (!rst_n) begin
      p_awv <= 0; p_awr <= 0; p_wv <= 0; p_wr <= 0; p_arv <= 0; p_arr <= 0; p_wl <= 0;
      p_awa <= '0; p_ara <= '0; p_wd <= '0; hold_err <= 0;
    end else begin
      if (p_awv && !p_awr && !(awvalid && awaddr == p_awa)) hold_err <= hold_err + 1;
      if (p_wv && !p_wr && !(wvalid && wdata == p_wd && wlast == p_wl)) hold_err <= hold_err + 1;
      if (p_arv && !p_arr && !(arvalid && araddr == p_ara)) hold_err <= hold_err + 1;
      p_awv <= awvalid; p_awr <= awready; p_awa <= awaddr;
      p_wv <= wvalid; p_wr <= wready; p_wd <= wdata; p_wl <= wlast;
      p_arv <= arvalid; p_arr <= arready; p_ara <= araddr;
      if (clr) hold_err <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_faults();
    for (int i = 0; i < TOTAL; i++) begin
      flip_d[i] = 1'b0; bad_r[i] = 1'b0; inv_l[i] = 1'b0;
    end
    bad_b_burst = -1;
    stall_en = 1'b0;
  endtask

  task automatic clear_logs();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 8000) begin
      @(negedge clk);
      n++;
    end
    chk(done, req, "run finished before timeout", done, 1);
  endtask

  task automatic check_memory(input string req);
    int bad = 0;
    for (int k = 0; k < TOTAL; k++) if (mem[k] !== DW'(k)) bad++;
    chk(bad == 0, req, "memory beats not equal to running counter", bad, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!awvalid && !wvalid && !arvalid, "R1", "valids low after reset",
        {awvalid, wvalid, arvalid}, 0);
    chk(!done && !pass, "R1", "done/pass low after reset", {done, pass}, 0);
    chk(err_count == 0, "R1", "error count after reset", err_count, 0);
  endtask

  task automatic t_clean_run();
    clear_faults();
    clear_logs();
    pulse_start();
    wait_done("R9");
    chk(pass && err_count == 0, "R9", "pass on clean run", pass, 1);
    chk(aw_n == NB, "R2", "write bursts issued", aw_n, NB);
    for (int i = 0; i < NB; i++) begin
      chk(aw_log[i] == AW'(i * 1024), "R2", "write burst address", aw_log[i], i * 1024);
      chk(ar_log[i] == AW'(i * 1024), "R7", "read burst address", ar_log[i], i * 1024);
    end
    chk(attr_err == 0, "R2", "len/size/burst attributes wrong", attr_err, 0);
    check_memory("R4");
    chk(strb_err == 0, "R4", "strobe not all ones", strb_err, 0);
    chk(wlast_err == 0, "R4", "wlast misplaced", wlast_err, 0);
    chk(proto_err == 0, "R5", "AW while write outstanding", proto_err, 0);
    chk(order_err == 0, "R7", "AR before writes complete", order_err, 0);
  endtask

  task automatic t_backpressure();
    clear_faults();
    for (int k = 0; k < TOTAL; k++) mem[k] = '0;
    stall_en = 1'b1;
    clear_logs();
    pulse_start();
    wait_done("R3");
    chk(hold_err == 0, "R3", "request dropped or changed while stalled", hold_err, 0);
    chk(pass, "R3", "pass under random stalls", pass, 1);
    check_memory("R3");
    chk(proto_err == 0 && order_err == 0, "R5", "ordering under stalls",
        proto_err + order_err, 0);
    stall_en = 1'b0;
  endtask

  task automatic t_done_and_busy_start();
    clear_faults();
    repeat (30) @(negedge clk);
    chk(done, "R9", "done held while idle", done, 1);
    clear_logs();
    pulse_start();
    chk(!done, "R9", "done cleared by new start", done, 0);
    repeat (100) @(negedge clk);
    pulse_start();
    repeat (400) @(negedge clk);
    pulse_start();
    wait_done("R10");
    chk(aw_n == NB && ar_n == NB, "R10", "bursts with mid-run starts", aw_n + ar_n, 2 * NB);
    chk(pass, "R10", "mid-run start ignored", pass, 1);
  endtask

  task automatic t_bresp_error();
    clear_faults();
    bad_b_burst = 2;
    clear_logs();
    pulse_start();
    wait_done("R6");
    chk(err_count == 1, "R6", "error count after one bad BRESP", err_count, 1);
    chk(!pass, "R6", "pass low after bad BRESP", pass, 0);
    chk(ar_n == NB, "R6", "read pass still runs", ar_n, NB);
  endtask

  task automatic t_read_faults();
    clear_faults();
    flip_d[5]   = 1'b1;                  // data only: +1
    flip_d[70]  = 1'b1; bad_r[70] = 1'b1; // data and resp: +2
    inv_l[191]  = 1'b1;                  // missing last: +1
    inv_l[200]  = 1'b1;                  // early last: +1
    clear_logs();
    pulse_start();
    wait_done("R8");
    chk(err_count == 5, "R8", "read fault tally", err_count, 5);
    chk(!pass, "R8", "pass low on read faults", pass, 0);
  endtask

  task automatic t_saturate();
    clear_faults();
    for (int k = 0; k < TOTAL; k++) flip_d[k] = 1'b1;
    clear_logs();
    pulse_start();
    wait_done("R11");
    chk(err_count == '1, "R11", "error count saturates", err_count, 15);
    clear_faults();
    clear_logs();
    pulse_start();
    chk(err_count == 0, "R11", "start clears error count", err_count, 0);
    wait_done("R11");
    chk(pass && err_count == 0, "R11", "clean run after saturation", err_count, 0);
  endtask

  initial begin
    clear_faults();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_clean_run();
    t_backpressure();
    t_done_and_busy_start();
    t_bresp_error();
    t_read_faults();
    t_saturate();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule